// File: doc/BRIEF.md
# Four-State Reactive Mealy Controller

This block is a small clocked controller with four states, here called ST_IDLE (A), ST_RUN (B), ST_WAIT (C) and ST_DONE (D). In each state it looks at exactly one of three one-bit inputs (`go_i` in ST_IDLE, `rdy_i` in ST_RUN, `sel_i` in ST_WAIT) and ignores the other two. It then takes one transition, and that transition writes only some of the three registered outputs. The outputs are `flag_o`, `mark_o` and a small code `code_o`. An output that the transition does not name keeps its old value. ST_DONE has no input. It always returns to ST_IDLE and writes no output.

The code output takes one of two parameterised constants, CODE_A and CODE_B. An enable input gates all evaluation: while `en_i` is low, the state and all outputs hold. Reset is synchronous and active high. The block suits control-dominated glue logic where outputs act as sticky levels that individual edges set or clear.

Transitions:
- T_IDLE_GO: in ST_IDLE with go=1, set code=CODE_A and move to ST_RUN.
- T_IDLE_SKIP: in ST_IDLE with go=0, set code=CODE_B and move to ST_DONE.
- T_RUN_STAY: in ST_RUN with rdy=0, set mark=1 and stay in ST_RUN.
- T_RUN_ADV: in ST_RUN with rdy=1, clear flag and move to ST_WAIT.
- T_WAIT_STAY: in ST_WAIT with sel=0, clear flag and stay in ST_WAIT.
- T_WAIT_ADV: in ST_WAIT with sel=1, set flag=1 and move to ST_DONE.
- T_DONE_RET: in ST_DONE, with no input tested, move to ST_IDLE and write no output.

Top module: `mealy4_ctrl`

## Requirements
- R1: A synchronous reset gives state ST_IDLE, flag_o=0, mark_o=0 and code_o=CODE_B, seen one clock edge after rst_i is high.
- R2: In ST_IDLE with go_i=1, code_o becomes CODE_A and the state moves to ST_RUN. In ST_IDLE with go_i=0, code_o becomes CODE_B and the state moves to ST_DONE. flag_o and mark_o hold in both cases.
- R3: In ST_RUN with rdy_i=0, mark_o becomes 1 and the state stays ST_RUN. flag_o and code_o hold.
- R4: In ST_RUN with rdy_i=1, flag_o becomes 0 and the state moves to ST_WAIT. mark_o and code_o hold.
- R5: In ST_WAIT with sel_i=0, flag_o becomes 0 and the state stays ST_WAIT. In ST_WAIT with sel_i=1, flag_o becomes 1 and the state moves to ST_DONE. mark_o and code_o hold in both cases.
- R6: ST_DONE always moves to ST_IDLE on the next enabled cycle and leaves all outputs unchanged.
- R7: While en_i=0, the state and all outputs hold their values whatever the other inputs do.
- R8: Only the input that belongs to the current state affects the result. The other two inputs have no effect.
- R9: state_o reports the current state with the encoding ST_IDLE=0, ST_RUN=1, ST_WAIT=2, ST_DONE=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Evaluation enable |
| go_i | input | 1 | Input tested in ST_IDLE |
| rdy_i | input | 1 | Input tested in ST_RUN |
| sel_i | input | 1 | Input tested in ST_WAIT |
| flag_o | output | 1 | Sticky flag, written by T_RUN_ADV, T_WAIT_STAY and T_WAIT_ADV |
| mark_o | output | 1 | Sticky mark, set by T_RUN_STAY |
| code_o | output | CODE_W | Code, CODE_A or CODE_B |
| state_o | output | 2 | Current state code |

## Verification
A wrong state register shows up first at state_o, one enabled edge after the bad transition. It then shows at the outputs on the next enabled edge, because the wrong input gets tested: code_o changes out of turn, or mark_o or flag_o moves in the wrong state. An output that fails to hold is visible right after the edge of a transition that should not have named it. Holds therefore get checked on every enabled cycle, not only on the edges that write that output.

// File: rtl/mealy4_pkg.sv
package mealy4_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } state_t;

    // write-enable and value for one output on a transition
    typedef struct packed {
        logic wr_flag;
        logic flag_v;
        logic wr_mark;
        logic mark_v;
        logic wr_code;
        logic code_sel_a;
    } out_cmd_t;
endpackage

// File: rtl/mealy4_next.sv
module mealy4_next
    import mealy4_pkg::*;
(
    input  state_t   cur_i,
    input  logic     go_i,
    input  logic     rdy_i,
    input  logic     sel_i,
    output state_t   nxt_o,
    output out_cmd_t cmd_o
);
    always_comb begin
        nxt_o = cur_i;
        cmd_o = '0;
        unique case (cur_i)
            ST_IDLE: begin
                cmd_o.wr_code = 1'b1;
                if (go_i) begin
                    cmd_o.code_sel_a = 1'b1;
                    nxt_o = ST_RUN;      // T_IDLE_GO
                end else begin
                    nxt_o = ST_DONE;     // T_IDLE_SKIP
                end
            end
            ST_RUN: begin
                if (rdy_i) begin
                    cmd_o.wr_flag = 1'b1;
                    nxt_o = ST_WAIT;     // T_RUN_ADV
                end else begin
                    cmd_o.wr_mark = 1'b1;
                    cmd_o.mark_v  = 1'b1; // T_RUN_STAY
                end
            end
            ST_WAIT: begin
                cmd_o.wr_flag = 1'b1;
                if (sel_i) begin
                    cmd_o.flag_v = 1'b1;
                    nxt_o = ST_DONE;     // T_WAIT_ADV
                end
            end
            ST_DONE: nxt_o = ST_IDLE;    // T_DONE_RET
            default: nxt_o = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mealy4_outreg.sv
module mealy4_outreg
    import mealy4_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter logic [CODE_W-1:0] CODE_A = 4'h5,
    parameter logic [CODE_W-1:0] CODE_B = 4'hA
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  out_cmd_t          cmd_i,
    output logic              flag_o,
    output logic              mark_o,
    output logic [CODE_W-1:0] code_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_o <= 1'b0;
            mark_o <= 1'b0;
            code_o <= CODE_B;
        end else if (en_i) begin
            if (cmd_i.wr_flag) flag_o <= cmd_i.flag_v;
            if (cmd_i.wr_mark) mark_o <= cmd_i.mark_v;
            if (cmd_i.wr_code) code_o <= cmd_i.code_sel_a ? CODE_A : CODE_B;
        end
    end
endmodule

// File: rtl/mealy4_ctrl.sv
module mealy4_ctrl
    import mealy4_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter logic [CODE_W-1:0] CODE_A = 4'h5,
    parameter logic [CODE_W-1:0] CODE_B = 4'hA
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              go_i,
    input  logic              rdy_i,
    input  logic              sel_i,
    output logic              flag_o,
    output logic              mark_o,
    output logic [CODE_W-1:0] code_o,
    output logic [1:0]        state_o
);
    state_t   cur_q, nxt;
    out_cmd_t cmd;

    mealy4_next u_next (
        .cur_i(cur_q), .go_i(go_i), .rdy_i(rdy_i), .sel_i(sel_i),
        .nxt_o(nxt), .cmd_o(cmd)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)     cur_q <= ST_IDLE;
        else if (en_i) cur_q <= nxt;
    end

    mealy4_outreg #(.CODE_W(CODE_W), .CODE_A(CODE_A), .CODE_B(CODE_B)) u_out (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .cmd_i(cmd),
        .flag_o(flag_o), .mark_o(mark_o), .code_o(code_o)
    );

    assign state_o = cur_q;
endmodule

// File: rtl/mealy4_ctrl_chk.sv
module mealy4_ctrl_chk #(
    parameter int CODE_W = 4,
    parameter logic [CODE_W-1:0] CODE_A = 4'h5,
    parameter logic [CODE_W-1:0] CODE_B = 4'hA
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              en_i,
    input logic              go_i,
    input logic              rdy_i,
    input logic              sel_i,
    input logic              flag_o,
    input logic              mark_o,
    input logic [CODE_W-1:0] code_o,
    input logic [1:0]        state_o
);
    logic seen_rst;
    always_ff @(posedge clk_i) seen_rst <= rst_i | seen_rst;

    always_ff @(posedge clk_i) begin
        if (seen_rst && !rst_i && $past(rst_i))
            p_reset_vals_r1: assert (state_o == 2'd0 && !flag_o && !mark_o && code_o == CODE_B);
    end

    p_idle_go_r2: assert property (@(posedge clk_i) disable iff (rst_i || !seen_rst)
        (en_i && state_o == 2'd0 && go_i) |=> (state_o == 2'd1 && code_o == CODE_A));
    p_idle_skip_r2: assert property (@(posedge clk_i) disable iff (rst_i || !seen_rst)
        (en_i && state_o == 2'd0 && !go_i) |=> (state_o == 2'd3 && code_o == CODE_B));
    p_run_stay_r3: assert property (@(posedge clk_i) disable iff (rst_i || !seen_rst)
        (en_i && state_o == 2'd1 && !rdy_i) |=> (state_o == 2'd1 && mark_o));
    p_run_adv_r4: assert property (@(posedge clk_i) disable iff (rst_i || !seen_rst)
        (en_i && state_o == 2'd1 && rdy_i) |=> (state_o == 2'd2 && !flag_o && $stable(mark_o)));
    p_wait_r5: assert property (@(posedge clk_i) disable iff (rst_i || !seen_rst)
        (en_i && state_o == 2'd2) |=> (flag_o == $past(sel_i) && $stable(code_o)));
    p_done_ret_r6: assert property (@(posedge clk_i) disable iff (rst_i || !seen_rst)
        (en_i && state_o == 2'd3) |=> (state_o == 2'd0 && $stable(flag_o) && $stable(mark_o) && $stable(code_o)));
    p_freeze_r7: assert property (@(posedge clk_i) disable iff (rst_i || !seen_rst)
        !en_i |=> ($stable(state_o) && $stable(flag_o) && $stable(mark_o) && $stable(code_o)));
endmodule

bind mealy4_ctrl mealy4_ctrl_chk #(.CODE_W(CODE_W), .CODE_A(CODE_A), .CODE_B(CODE_B)) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .go_i(go_i), .rdy_i(rdy_i), .sel_i(sel_i),
    .flag_o(flag_o), .mark_o(mark_o), .code_o(code_o), .state_o(state_o)
);

// File: tb/test_mealy4_ctrl.sv
`timescale 1ns/1ps
module test_mealy4_ctrl;
    localparam int W = 4;
    localparam logic [W-1:0] CA = 4'h5;
    localparam logic [W-1:0] CB = 4'hA;

    logic clk = 1'b0;
    logic rst, en, go, rdy, sel;
    logic flag, mark;
    logic [W-1:0] code;
    logic [1:0] st;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]   st;
        logic         flag;
        logic         mark;
        logic [W-1:0] code;
        string        req;
    } exp_t;
    exp_t q[$];

    // bench model of the expected state, built from the requirements
    logic [1:0]   m_st;
    logic         m_flag, m_mark;
    logic [W-1:0] m_code;

    always #10 clk = ~clk;

    mealy4_ctrl #(.CODE_W(W), .CODE_A(CA), .CODE_B(CB)) i_mealy4_ctrl (
        .clk_i(clk), .rst_i(rst), .en_i(en), .go_i(go), .rdy_i(rdy), .sel_i(sel),
        .flag_o(flag), .mark_o(mark), .code_o(code), .state_o(st)
    );

    // drive one cycle and push the expected result
    task automatic step(input logic e, input logic g, input logic r, input logic s,
                        input string req);
        @(negedge clk);
        rst = 1'b0; en = e; go = g; rdy = r; sel = s;
        if (e) begin
            case (m_st)
                2'd0: begin m_code = g ? CA : CB; m_st = g ? 2'd1 : 2'd3; end
                2'd1: if (r) begin m_flag = 1'b0; m_st = 2'd2; end else m_mark = 1'b1;
                2'd2: begin m_flag = s; if (s) m_st = 2'd3; end
                default: m_st = 2'd0;
            endcase
        end
        q.push_back('{m_st, m_flag, m_mark, m_code, req});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; go = 1'b1; rdy = 1'b1; sel = 1'b1;
        m_st = 2'd0; m_flag = 1'b0; m_mark = 1'b0; m_code = CB;
        q.push_back('{m_st, m_flag, m_mark, m_code, "R1"});
    endtask

    // monitor: sample after the edge, away from it
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (st !== e.st || flag !== e.flag || mark !== e.mark || code !== e.code) begin
                    n_fail++;
                    $display("FAIL %s: got st=%0d flag=%0b mark=%0b code=%h, expected st=%0d flag=%0b mark=%0b code=%h",
                             e.req, st, flag, mark, code, e.st, e.flag, e.mark, e.code);
                end
            end
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; go = 1'b0; rdy = 1'b0; sel = 1'b0;
        do_reset();                           // R1
        step(1, 1, 1, 1, "R2");               // go -> RUN, code A
        step(1, 0, 0, 1, "R3");               // RUN stay, mark=1; go,sel ignored (R8)
        step(1, 1, 0, 0, "R8");               // still RUN
        step(0, 0, 1, 1, "R7");               // frozen
        step(0, 1, 1, 0, "R7");
        step(1, 0, 1, 0, "R4");               // RUN -> WAIT, flag 0
        step(1, 1, 1, 0, "R5");               // WAIT stay, flag 0; go,rdy ignored
        step(1, 0, 0, 1, "R5");               // WAIT -> DONE, flag 1
        step(1, 0, 0, 0, "R6");               // DONE -> IDLE, outputs hold
        step(0, 1, 0, 0, "R7");
        step(1, 0, 1, 1, "R2");               // IDLE skip -> DONE, code B
        step(1, 1, 1, 1, "R6");               // DONE -> IDLE; inputs ignored
        step(1, 1, 0, 0, "R9");               // -> RUN, code A
        step(1, 0, 1, 0, "R9");               // -> WAIT
        step(1, 0, 0, 1, "R9");               // -> DONE
        do_reset();                           // R1 from mid-run state
        step(1, 1, 0, 0, "R2");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R3");
        step(1, 0, 1, 0, "R4");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 0, "R5");
        step(1, 0, 0, 1, "R5");
        step(1, 0, 0, 0, "R6");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule